// File: doc/BRIEF.md
# Modem Baud Tick Generator

This block derives three clock-enable strobes from a single crystal-rate clock: a reference tick, a modem tick and a baud tick. Every strobe is one input-clock cycle wide and lives in the input clock domain, so downstream logic keeps running on the crystal clock and uses the strobes as enables. No derived clocks are created.

Three configuration fields set the ratios. A 3-bit reference field picks an integer divide from 2 to 8. A 3-bit first-stage field picks one of eight ratios, some of them fractional. These ratios are built from a prescaler that divides by 2.5, 3 or 4, followed by an integer postscaler that divides by 1, 3, 5 or 16. A 2-bit second-stage field picks a power-of-two divide from 1 to 8. The baud tick is always every eighth modem tick.

The fields are parallel inputs. They are captured only while `reload` is high, and `reload` also restarts every divider.

The prescaler is a five-state machine with states PH_A, PH_B, PH_C, PH_D and PH_E. Each state counts the reference ticks seen since the last wrap. A reference tick always moves PH_A to PH_B.

- From PH_B a tick moves to PH_C. It pulses only in ÷2.5 mode.
- From PH_C a tick wraps to PH_A with a pulse in ÷3 mode, and otherwise moves to PH_D.
- From PH_D a tick wraps to PH_A with a pulse in ÷4 mode, and otherwise moves to PH_E.
- From PH_E, which only ÷2.5 mode reaches, a tick wraps to PH_A with a pulse.
- Reload or reset forces PH_A from any state.

Top module: `baud_tick_gen`

## Requirements
- R1: With reference field n in 1..7, `ref_tick` is high for one cycle every n+1 input cycles.
- R2: A reference field of 0 divides by 2. If it is loaded by a reload, `config_error` goes high on the next cycle and stays high until reset.
- R3: First-stage codes give these ratios of reference ticks per stage output: 0 → 2.5, 1 → 3, 2 → 4, 3 → 7.5, 4 → 12.5, 5 → 40, 6 → 48, 7 → 64. The composite codes are the prescaler followed by the postscaler: 3 = 2.5 then 3, 4 = 2.5 then 5, 5 = 2.5 then 16, 6 = 3 then 16, 7 = 4 then 16. The postscaler emits on every k-th prescaler pulse.
- R4: In ÷2.5 mode the prescaler pulses on the 2nd and 5th reference tick of every group of five counted from reload. Its intervals therefore alternate 2, 3, 2, 3.
- R5: Second-stage codes 0, 1, 2 and 3 divide first-stage outputs by 1, 2, 4 and 8. `modem_tick` is the resulting strobe.
- R6: `baud_tick` fires on every 8th modem tick counted from reload.
- R7: `modem_tick` is high only in cycles where `ref_tick` is high. `baud_tick` is high only in cycles where `modem_tick` is high.
- R8: Reset loads reference field 2, first-stage code 4 and second-stage code 0, and clears `config_error`. Configuration inputs have no effect while `reload` is low.
- R9: While `reload` is high, no tick is produced, all counters are cleared and the fields are latched. Counting the first cycle with `reload` low as cycle 0, the first `ref_tick` falls in cycle n (the divide value minus one).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload | input | 1 | Synchronous clear and configuration capture |
| ref_div_cfg | input | 3 | Reference divide field (divide = value + 1, 0 treated as 2) |
| stage1_cfg | input | 3 | First-stage ratio code |
| stage2_cfg | input | 2 | Second-stage power-of-two code |
| ref_tick | output | 1 | Reference enable strobe |
| modem_tick | output | 1 | Modem enable strobe |
| baud_tick | output | 1 | Baud enable strobe |
| config_error | output | 1 | Sticky flag for a zero reference field |

## Verification
The bench predicts the exact cycle of every strobe and runs through each first-stage code. The fractional codes (0, 3, 4, 5) show whether the ÷2.5 prescaler keeps the 2-then-3 phase. The integer codes (1, 2, 6, 7) show whether the prescaler wraps at the right state and the ×16 postscaler counts correctly. Reference divides of 2, 3, 4 and 8, together with every second-stage code, separate an off-by-one in the integer counters from a wrong power of two. A zero reference field, a multi-cycle reload and a window in which the inputs change without reload expose missing error latching, stale counters and configuration leaking in outside reload.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    localparam int REF_FIELD_W = 3;
    localparam int S1_FIELD_W  = 3;
    localparam int S2_FIELD_W  = 2;
    localparam int POST_W      = 4;
    localparam int S2_CNT_W    = (1 << S2_FIELD_W) - 1;

    typedef enum logic [1:0] {
        PRE_2P5 = 2'd0,
        PRE_3   = 2'd1,
        PRE_4   = 2'd2
    } pre_mode_e;

    typedef struct packed {
        pre_mode_e         pre;
        logic [POST_W-1:0] post_last;
    } stage1_set_t;

    // Split a first-stage code into prescaler mode and postscaler terminal count.
    function automatic stage1_set_t decode_stage1(input logic [S1_FIELD_W-1:0] code);
        stage1_set_t s;
        case (code)
            3'd0:    begin s.pre = PRE_2P5; s.post_last = 4'd0;  end
            3'd1:    begin s.pre = PRE_3;   s.post_last = 4'd0;  end
            3'd2:    begin s.pre = PRE_4;   s.post_last = 4'd0;  end
            3'd3:    begin s.pre = PRE_2P5; s.post_last = 4'd2;  end
            3'd4:    begin s.pre = PRE_2P5; s.post_last = 4'd4;  end
            3'd5:    begin s.pre = PRE_2P5; s.post_last = 4'd15; end
            3'd6:    begin s.pre = PRE_3;   s.post_last = 4'd15; end
            default: begin s.pre = PRE_4;   s.post_last = 4'd15; end
        endcase
        return s;
    endfunction

    // Reference terminal count: field value, with 0 treated as divide-by-2.
    function automatic logic [REF_FIELD_W-1:0] ref_last(input logic [REF_FIELD_W-1:0] code);
        return (code == '0) ? REF_FIELD_W'(1) : code;
    endfunction

    // Second-stage terminal count: 2**code - 1.
    function automatic logic [S2_CNT_W-1:0] stage2_last(input logic [S2_FIELD_W-1:0] code);
        logic [S2_CNT_W:0] one_hot;
        one_hot = (S2_CNT_W+1)'(1) << code;
        return S2_CNT_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/tick_div.sv
module tick_div #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] last,
    output logic         tick
);

    logic [W-1:0] cnt;
    logic         at_end;

    assign at_end = (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= at_end ? '0 : cnt + W'(1);
        end
    end

    assign tick = en && !clr && at_end;

endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler
    import baud_tick_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      en,
    input  pre_mode_e mode,
    output logic      pulse
);

    typedef enum logic [2:0] {
        PH_A = 3'd0,
        PH_B = 3'd1,
        PH_C = 3'd2,
        PH_D = 3'd3,
        PH_E = 3'd4
    } ph_e;

    ph_e state, nxt;
    logic pulse_c;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_A;
        end else begin
            state <= nxt;
        end
    end

    // Transition and output decode
    always_comb begin
        nxt     = state;
        pulse_c = 1'b0;
        if (clr) begin
            nxt = PH_A;
        end else if (en) begin
            unique case (state)
                PH_A: nxt = PH_B;
                PH_B: begin
                    nxt     = PH_C;
                    pulse_c = (mode == PRE_2P5);
                end
                PH_C: begin
                    if (mode == PRE_3) begin
                        nxt     = PH_A;
                        pulse_c = 1'b1;
                    end else begin
                        nxt = PH_D;
                    end
                end
                PH_D: begin
                    if (mode == PRE_4) begin
                        nxt     = PH_A;
                        pulse_c = 1'b1;
                    end else begin
                        nxt = PH_E;
                    end
                end
                PH_E: begin
                    nxt     = PH_A;
                    pulse_c = 1'b1;
                end
                default: nxt = PH_A;
            endcase
        end
    end

    assign pulse = pulse_c;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter logic [REF_FIELD_W-1:0] DEF_REF  = 3'd2,
    parameter logic [S1_FIELD_W-1:0]  DEF_S1   = 3'd4,
    parameter logic [S2_FIELD_W-1:0]  DEF_S2   = 2'd0,
    parameter int                     BAUD_DIV = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reload,
    input  logic [REF_FIELD_W-1:0] ref_div_cfg,
    input  logic [S1_FIELD_W-1:0]  stage1_cfg,
    input  logic [S2_FIELD_W-1:0]  stage2_cfg,
    output logic                   ref_tick,
    output logic                   modem_tick,
    output logic                   baud_tick,
    output logic                   config_error
);

    localparam int BAUD_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;

    logic [REF_FIELD_W-1:0] ref_q;
    logic [S1_FIELD_W-1:0]  s1_q;
    logic [S2_FIELD_W-1:0]  s2_q;
    logic                   err_q;

    stage1_set_t            s1_set;
    logic [S2_CNT_W-1:0]    s2_last;
    logic                   ref_p, pre_p, s1_p, mod_p, baud_p;

    // Configuration capture and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= DEF_REF;
            s1_q  <= DEF_S1;
            s2_q  <= DEF_S2;
            err_q <= 1'b0;
        end else if (reload) begin
            ref_q <= ref_div_cfg;
            s1_q  <= stage1_cfg;
            s2_q  <= stage2_cfg;
            if (ref_div_cfg == '0) begin
                err_q <= 1'b1;
            end
        end
    end

    assign s1_set  = decode_stage1(s1_q);
    assign s2_last = stage2_last(s2_q);

    tick_div #(.W(REF_FIELD_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .clr(reload), .en(1'b1),
        .last(ref_last(ref_q)), .tick(ref_p)
    );

    frac_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .clr(reload), .en(ref_p),
        .mode(s1_set.pre), .pulse(pre_p)
    );

    tick_div #(.W(POST_W)) u_post (
        .clk(clk), .rst_n(rst_n), .clr(reload), .en(pre_p),
        .last(s1_set.post_last), .tick(s1_p)
    );

    tick_div #(.W(S2_CNT_W)) u_s2 (
        .clk(clk), .rst_n(rst_n), .clr(reload), .en(s1_p),
        .last(s2_last), .tick(mod_p)
    );

    tick_div #(.W(BAUD_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .clr(reload), .en(mod_p),
        .last(BAUD_W'(BAUD_DIV - 1)), .tick(baud_p)
    );

    // Outputs
    always_comb begin
        ref_tick     = ref_p;
        modem_tick   = mod_p;
        baud_tick    = baud_p;
        config_error = err_q;
    end

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reload,
    input logic [2:0] ref_div_cfg,
    input logic       ref_tick,
    input logic       modem_tick,
    input logic       baud_tick,
    input logic       config_error
);

    a_r1_ref_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);

    a_r2_error_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && ref_div_cfg == 3'd0) |=> config_error);

    a_r2_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |=> config_error);

    a_r7_modem_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        modem_tick |-> ref_tick);

    a_r7_baud_on_modem: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> modem_tick);

    a_r9_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> !(ref_tick || modem_tick || baud_tick));

endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reload(reload), .ref_div_cfg(ref_div_cfg),
    .ref_tick(ref_tick), .modem_tick(modem_tick), .baud_tick(baud_tick),
    .config_error(config_error)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reload = 1'b0;
    logic [2:0] ref_div_cfg = 3'd7;
    logic [2:0] stage1_cfg = 3'd7;
    logic [1:0] stage2_cfg = 2'd3;
    logic       ref_tick, modem_tick, baud_tick, config_error;

    int    nchk = 0;
    int    nfail = 0;
    int    cyc_total = 0;
    int    base = 0;
    int    exp_q[$];
    string win_tag = "R8";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    baud_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .reload(reload),
        .ref_div_cfg(ref_div_cfg), .stage1_cfg(stage1_cfg), .stage2_cfg(stage2_cfg),
        .ref_tick(ref_tick), .modem_tick(modem_tick), .baud_tick(baud_tick),
        .config_error(config_error)
    );

    function automatic string kind_name(int k);
        return (k == 0) ? "ref" : (k == 1) ? "modem" : "baud";
    endfunction

    task automatic chk(string tag, int act, int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Driver-side model: push expected (cycle*4 + kind) items, kind 0 ref, 1 modem, 2 baud
    task automatic push_exp(int b, int rc, int m1, int m2, int len);
        int n = (rc == 0) ? 2 : rc + 1;
        int post = (m1 == 3) ? 3 : (m1 == 4) ? 5 : (m1 >= 5) ? 16 : 1;
        int pmode = (m1 == 0 || m1 == 3 || m1 == 4 || m1 == 5) ? 25 :
                    (m1 == 1 || m1 == 6) ? 3 : 4;
        int d2 = 1 << m2;
        int nref = 0, npre = 0, ns1 = 0, nmod = 0;
        for (int c = 0; c < len; c++) begin
            if ((c + 1) % n == 0) begin
                bit pre;
                exp_q.push_back((b + c) * 4);
                nref++;
                if (pmode == 25) pre = (nref % 5 == 2) || (nref % 5 == 0);
                else             pre = (nref % pmode == 0);
                if (pre) begin
                    npre++;
                    if (npre % post == 0) begin
                        ns1++;
                        if (ns1 % d2 == 0) begin
                            exp_q.push_back((b + c) * 4 + 1);
                            nmod++;
                            if (nmod % 8 == 0) exp_q.push_back((b + c) * 4 + 2);
                        end
                    end
                end
            end
        end
    endtask

    task automatic leftover();
        while (exp_q.size() > 0) begin
            int it = exp_q.pop_front();
            nchk++;
            nfail++;
            $display("FAIL %s %s tick missing: actual 0 expected 1 at cycle %0d",
                     win_tag, kind_name(it % 4), it / 4 - base);
        end
    endtask

    // Entered at posedge+1; returns at posedge+1
    task automatic run_win(int rc, int m1, int m2, int len, int hold, string tag);
        win_tag     = tag;
        reload      = 1'b1;
        ref_div_cfg = 3'(rc);
        stage1_cfg  = 3'(m1);
        stage2_cfg  = 2'(m2);
        repeat (hold) @(posedge clk);
        #1 reload = 1'b0;
        base = cyc_total;
        push_exp(base, rc, m1, m2, len);
        repeat (len) @(posedge clk);
        #1 leftover();
    endtask

    // Reset window: defaults apply; inputs change without reload and must be ignored (R8)
    task automatic reset_win(int len, string tag);
        win_tag = tag;
        rst_n = 1'b0;
        ref_div_cfg = 3'd7; stage1_cfg = 3'd7; stage2_cfg = 2'd3;
        repeat (3) @(posedge clk);
        #1 chk("R8 config_error during reset", config_error, 0);
        chk("R8 no ticks during reset", ref_tick | modem_tick | baud_tick, 0);
        rst_n = 1'b1;
        base = cyc_total;
        push_exp(base, 2, 4, 0, len);
        repeat (len / 2) @(posedge clk);
        #1 ref_div_cfg = 3'd1; stage1_cfg = 3'd0; stage2_cfg = 2'd0;
        repeat (len - len / 2) @(posedge clk);
        #1 leftover();
        chk("R8 config_error after reset", config_error, 0);
    endtask

    // Monitor: compares observed strobes with the scoreboard queue
    always @(negedge clk) begin
        logic [2:0] obs;
        obs = {baud_tick, modem_tick, ref_tick};
        for (int k = 0; k < 3; k++) begin
            bit e_v;
            e_v = 1'b0;
            if (exp_q.size() > 0 && exp_q[0] == cyc_total * 4 + k) begin
                e_v = 1'b1;
                void'(exp_q.pop_front());
            end
            if (obs[k] || e_v) begin
                nchk++;
                if (obs[k] != e_v) begin
                    nfail++;
                    $display("FAIL %s %s tick at cycle %0d: actual %0b expected %0b",
                             win_tag, kind_name(k), cyc_total - base, obs[k], e_v);
                end
            end
        end
        if (modem_tick) begin
            nchk++;
            if (!ref_tick) begin
                nfail++;
                $display("FAIL R7 modem without ref: actual ref %0b expected 1", ref_tick);
            end
        end
        if (baud_tick) begin
            nchk++;
            if (!modem_tick) begin
                nfail++;
                $display("FAIL R7 baud without modem: actual modem %0b expected 1", modem_tick);
            end
        end
        cyc_total++;
    end

    initial begin
        @(posedge clk);
        #1;
        reset_win(800, "R8 R3 R4 R6 R9");
        run_win(1, 0, 0, 300, 1, "R1 R4 R5 R6");
        run_win(0, 1, 2, 500, 1, "R2 R3 R5");
        chk("R2 config_error after zero field", config_error, 1);
        run_win(3, 3, 1, 1000, 3, "R3 R4 R5 R9");
        chk("R2 config_error sticky", config_error, 1);
        run_win(1, 5, 0, 1400, 1, "R3 R4");
        run_win(1, 6, 0, 800, 1, "R3");
        run_win(7, 2, 3, 4200, 1, "R1 R3 R5 R6");
        run_win(1, 7, 0, 1100, 2, "R3 R9");
        run_win(5, 4, 2, 1800, 1, "R1 R4 R5");
        reset_win(400, "R8 R9");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule